// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM device from power-on to a usable state before the main memory controller is allowed to touch it. After reset it holds the command pins at NOP for a programmable clock and power stabilization interval. It then spends one cycle in a dedicated NOP step and issues a precharge that closes every bank. Two auto-refresh commands follow, and a mode-register load writes a parameterized operating-mode word. Each command is followed by a timed gap of NOP cycles.

When the last gap has elapsed, the block raises a completion flag and keeps it high until the next reset. From that point the command pins stay at NOP, and the main controller takes over the device. All pins are plain level signals. The block carries no data, so it has no valid/ready handshake.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the pins show NOP, `sd_addr` and `sd_ba` are zero and `init_done` is low. A reset asserted at any point restarts the whole sequence from the stabilization wait.
- R2: The command on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} uses these encodings: NOP = 4'b0111, PRECHARGE = 4'b0010, AUTO REFRESH = 4'b0001, LOAD MODE REGISTER = 4'b0000.
- R3: Let t count the rising edges since `rst` fell. For t < `STAB_CYCLES` the stabilization counter runs and the pins show NOP. At t = `STAB_CYCLES` the sequencer sits for exactly one cycle in its NOP step.
- R4: PRECHARGE appears at t = `STAB_CYCLES`+1, the cycle right after the NOP step. It has `sd_addr` bit 10 set, every other address bit zero and `sd_ba` zero, so that all banks are closed.
- R5: The first AUTO REFRESH appears exactly `T_RP` cycles after the PRECHARGE cycle.
- R6: Exactly two AUTO REFRESH commands are issued, the second exactly `T_RFC` cycles after the first.
- R7: LOAD MODE REGISTER appears exactly `T_RFC` cycles after the second refresh, with `sd_addr` = `MODE_WORD` and `sd_ba` = 0.
- R8: `init_done` rises exactly `T_MRD` cycles after the LOAD MODE REGISTER cycle. It then stays high, with NOP on the pins and zero address and bank, until reset.
- R9: Every cycle between two commands shows NOP with `sd_addr` and `sd_ba` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_done | output | 1 | Initialization complete, sticky until reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address lines (bit 10 for precharge-all, mode word for mode load) |
| sd_ba | output | BA_W | Bank address |

## Verification
The bench builds two instances at the same time.
- **First instance:** `STAB_CYCLES`=8, `T_RP`=2, `T_RFC`=5, `T_MRD`=3, with one mode word.
- **Second instance:** `STAB_CYCLES`=3, `T_RP`=4, `T_RFC`=2, `T_MRD`=2, with a different mode word.

These short intervals let the bench compare every output bit against an arithmetically computed schedule on every cycle. The comparison covers each full sequence, the shortest legal gap of two cycles, and a long tail after completion. A reset is forced in the middle of one instance's sequence while the other has already finished. This exercises the restart from both a partial and a completed state.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NOP,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RFC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_DONE
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam int NUM_REFRESH = 2;
  localparam int ALL_BANK_BIT = 10;

endpackage

// File: rtl/pwrup_stab_timer.sv
module pwrup_stab_timer #(
  parameter int LIMIT = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (run && (cnt_q != LAST))
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pwrup_gap_timer.sv
module pwrup_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwrup_cmd_decode.sv
module pwrup_cmd_decode
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
  input  init_state_e       state,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BANK_BIT;

  always_comb begin
    cmd  = CMD_NOP;
    addr = '0;
    ba   = '0;
    unique case (state)
      ST_PRE: begin
        cmd  = CMD_PRE;
        addr = ALL_BANKS;
      end
      ST_REF: cmd = CMD_REF;
      ST_MRS: begin
        cmd  = CMD_MRS;
        addr = MODE_WORD;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int BA_W        = 2,
  parameter int STAB_CYCLES = 20000,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 8,
  parameter int T_MRD       = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
  input  logic              clk,
  input  logic              rst,
  output logic              init_done,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  localparam int T_MAX = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                        : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
  localparam int GAP_W = $clog2(T_MAX) + 1;
  localparam int RC_W  = $clog2(NUM_REFRESH) + 1;

  init_state_e       state_q, state_d;
  logic [RC_W-1:0]   ref_cnt_q;
  logic              stab_exp;
  logic              gap_zero;
  logic              gap_load;
  logic [GAP_W-1:0]  gap_val;
  logic [3:0]        cmd;

  pwrup_stab_timer #(.LIMIT(STAB_CYCLES)) u_stab (
    .clk     (clk),
    .rst     (rst),
    .run     (state_q == ST_IDLE),
    .expired (stab_exp)
  );

  // Gap of T cycles between command cycles: T-1 wait cycles, counter from T-2.
  always_comb begin
    gap_load = 1'b1;
    gap_val  = '0;
    case (state_q)
      ST_PRE:  gap_val = GAP_W'(T_RP - 2);
      ST_REF:  gap_val = GAP_W'(T_RFC - 2);
      ST_MRS:  gap_val = GAP_W'(T_MRD - 2);
      default: gap_load = 1'b0;
    endcase
  end

  pwrup_gap_timer #(.W(GAP_W)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (stab_exp) state_d = ST_NOP;
      ST_NOP:      state_d = ST_PRE;
      ST_PRE:      state_d = ST_WAIT_RP;
      ST_WAIT_RP:  if (gap_zero) state_d = ST_REF;
      ST_REF:      state_d = ST_WAIT_RFC;
      ST_WAIT_RFC: if (gap_zero)
                     state_d = (ref_cnt_q == RC_W'(NUM_REFRESH)) ? ST_MRS : ST_REF;
      ST_MRS:      state_d = ST_WAIT_MRD;
      ST_WAIT_MRD: if (gap_zero) state_d = ST_DONE;
      ST_DONE:     state_d = ST_DONE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_REF)
        ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  pwrup_cmd_decode #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .MODE_WORD (MODE_WORD)
  ) u_dec (
    .state (state_q),
    .cmd   (cmd),
    .addr  (sd_addr),
    .ba    (sd_ba)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign init_done = (state_q == ST_DONE);
endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h033
) (
  input logic              clk,
  input logic              rst,
  input logic              init_done,
  input logic [3:0]        cmd,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba
);
  logic [1:0] refs_seen;

  always_ff @(posedge clk) begin
    if (rst)
      refs_seen <= '0;
    else if (cmd == CMD_REF && refs_seen != 2'd3)
      refs_seen <= refs_seen + 1'b1;
  end

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r8_nop_after_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == CMD_NOP && addr == '0 && ba == '0));

  a_r4_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> (addr[ALL_BANK_BIT] && ba == '0));

  a_r4_nop_before_pre: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> ($past(cmd) == CMD_NOP));

  a_r7_mode_word: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_MRS) |-> (addr == MODE_WORD && ba == '0));

  a_r6_two_refresh: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (refs_seen == 2'd2));

  a_r6_no_third_refresh: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> (refs_seen < 2'd2));

  a_r9_nop_after_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_NOP) |=> (cmd == CMD_NOP && addr == '0));
endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
  .ADDR_W    (ADDR_W),
  .BA_W      (BA_W),
  .MODE_WORD (MODE_WORD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .init_done (init_done),
  .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .addr      (sd_addr),
  .ba        (sd_ba)
);

// File: tb/sdram_pwrup_seq_bench.sv
module sdram_pwrup_seq_bench;
  localparam int AW = 13;
  localparam int BW = 2;

  localparam int A_ST = 8, A_RP = 2, A_RFC = 5, A_MRD = 3;
  localparam logic [AW-1:0] A_MODE = 13'h033;
  localparam int B_ST = 3, B_RP = 4, B_RFC = 2, B_MRD = 2;
  localparam logic [AW-1:0] B_MODE = 13'h1A2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          a_done, a_cs, a_ras, a_cas, a_we;
  logic [AW-1:0] a_addr;
  logic [BW-1:0] a_ba;
  logic          b_done, b_cs, b_ras, b_cas, b_we;
  logic [AW-1:0] b_addr;
  logic [BW-1:0] b_ba;

  sdram_pwrup_seq #(.ADDR_W(AW), .BA_W(BW), .STAB_CYCLES(A_ST), .T_RP(A_RP),
    .T_RFC(A_RFC), .T_MRD(A_MRD), .MODE_WORD(A_MODE)) u_sdram_pwrup_seq (
    .clk(clk), .rst(rst), .init_done(a_done), .sd_cs_n(a_cs), .sd_ras_n(a_ras),
    .sd_cas_n(a_cas), .sd_we_n(a_we), .sd_addr(a_addr), .sd_ba(a_ba));

  sdram_pwrup_seq #(.ADDR_W(AW), .BA_W(BW), .STAB_CYCLES(B_ST), .T_RP(B_RP),
    .T_RFC(B_RFC), .T_MRD(B_MRD), .MODE_WORD(B_MODE)) u_sdram_pwrup_seq_b (
    .clk(clk), .rst(rst), .init_done(b_done), .sd_cs_n(b_cs), .sd_ras_n(b_ras),
    .sd_cas_n(b_cas), .sd_we_n(b_we), .sd_addr(b_addr), .sd_ba(b_ba));

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // {done, cmd[3:0], addr[12:0], ba[1:0]}; encodings per R2
  function automatic logic [19:0] expect_out(int t, int st, int trp, int trfc,
                                             int tmrd, logic [AW-1:0] mode);
    int p, r1, r2, m, d;
    p = st + 1; r1 = p + trp; r2 = r1 + trfc; m = r2 + trfc; d = m + tmrd;
    if (t >= d)               return {1'b1, 4'b0111, 13'h0, 2'b0};
    if (t == p)               return {1'b0, 4'b0010, 13'h400, 2'b0};
    if (t == r1 || t == r2)   return {1'b0, 4'b0001, 13'h0, 2'b0};
    if (t == m)               return {1'b0, 4'b0000, mode, 2'b0};
    return {1'b0, 4'b0111, 13'h0, 2'b0};
  endfunction

  function automatic string req_of(int t, int st, int trp, int trfc, int tmrd);
    int p, r1, r2, m, d;
    p = st + 1; r1 = p + trp; r2 = r1 + trfc; m = r2 + trfc; d = m + tmrd;
    if (t == 0)   return "R1";
    if (t <= st)  return "R3";
    if (t == p)   return "R4";
    if (t == r1)  return "R5";
    if (t == r2)  return "R6";
    if (t == m)   return "R7";
    if (t >= d)   return "R8";
    return "R9";
  endfunction

  task automatic check(string tag, string inst, int t, logic [19:0] act, logic [19:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (enc R2) %s t=%0d actual=%h expected=%h", tag, inst, t, act, exp);
    end
  endtask

  task automatic check_both(int t, bit in_reset);
    logic [19:0] ea, eb;
    string ta, tb;
    if (in_reset) begin
      ea = {1'b0, 4'b0111, 13'h0, 2'b0}; eb = ea; ta = "R1"; tb = "R1";
    end else begin
      ea = expect_out(t, A_ST, A_RP, A_RFC, A_MRD, A_MODE);
      eb = expect_out(t, B_ST, B_RP, B_RFC, B_MRD, B_MODE);
      ta = req_of(t, A_ST, A_RP, A_RFC, A_MRD);
      tb = req_of(t, B_ST, B_RP, B_RFC, B_MRD);
    end
    check(ta, "A", t, {a_done, a_cs, a_ras, a_cas, a_we, a_addr, a_ba}, ea);
    check(tb, "B", t, {b_done, b_cs, b_ras, b_cas, b_we, b_addr, b_ba}, eb);
  endtask

  task automatic run_cycles(int n);
    // first sample right after reset release, then one per clock
    check_both(0, 1'b0);
    for (int t = 1; t <= n; t++) begin
      @(negedge clk);
      check_both(t, 1'b0);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 2000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected<=2000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_both(0, 1'b1);              // R1 during reset
    rst = 1'b0;
    run_cycles(16);                   // A interrupted mid-sequence, B already done
    rst = 1'b1;                       // R1 restart
    @(negedge clk);
    check_both(0, 1'b1);
    @(negedge clk);
    check_both(0, 1'b1);
    rst = 1'b0;
    run_cycles(45);                   // full sequences and long done tail (R8)
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule